// File: doc/BRIEF.md
# Earliest-Hit Channel Address Encoder

This block watches 64 synchronised discriminator hit flags and, once per bunch-crossing period, reports the address of the channel whose hit arrived first inside that crossing. It runs on a fast clock that ticks several times per crossing. A single-cycle crossing strobe marks the start of each crossing window. Arrival order is resolved to one fast-clock sample. A channel counts only when it shows a fresh rising edge, so a level that is still high from an earlier crossing cannot win again.

The result is a registered 6-bit address with a valid flag. It is published one cycle after the strobe that closes the window and then held for a full crossing period. The valid flag doubles as a fast OR of all unmasked channels. A per-channel mask removes noisy channels from both the address and the OR. The window before the first strobe after reset is never fully observed, so it is always published as empty.

Top module: `ehit_encoder`

## Requirements
- R1: The block takes 64 hit inputs and outputs the 6-bit binary index of the winning channel on `hitAddr` (channel 0 gives 0, channel 63 gives 63).
- R2: The channel whose rising edge is sampled earliest in the window wins, even when a lower-numbered channel rises in a later sample.
- R3: When several channels first rise in the same fast-clock sample, the lowest index wins.
- R4: Only a rising edge counts: the input is 0 in the previous fast-clock sample and 1 in the current one. A level held high across a strobe raises no hit in the new window.
- R5: A channel whose `chMask` bit is 1 can neither win nor raise `hitValid`. Other channels in the same window are still resolved.
- R6: `hitValid` acts as a fast OR. It is 1 for a window exactly when at least one unmasked rising edge was sampled in that window.
- R7: A window covers the sample taken in the strobe cycle and every sample up to, but not including, the next strobe cycle. Its result appears on the outputs one cycle after the closing strobe and stays unchanged until one cycle after the following strobe.
- R8: For a window with no unmasked rising edge, `hitValid` is 0 and `hitAddr` is 0.
- R9: During reset both outputs are 0. The first strobe after reset always publishes an empty result, whatever the inputs did before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock, a multiple of the crossing rate |
| rstN | input | 1 | Active-low synchronous reset |
| bxStrobe | input | 1 | One-cycle pulse that starts each crossing window |
| hitIn | input | 64 | Synchronised discriminator hit flags, one per channel |
| chMask | input | 64 | Per-channel mask; 1 excludes the channel |
| hitAddr | output | 6 | Index of the earliest channel of the last closed window |
| hitValid | output | 1 | Fast OR: some unmasked channel fired in the last closed window |

## Verification
Each window's result is due in the fast cycle right after the strobe that closes it: one register stage for the edge history, then the publish register loaded on that strobe. The bench therefore drives inputs at the falling edge and reads the outputs one nanosecond after the rising edge of the closing strobe. It then reads the same values again after each of the three following rising edges, to confirm they are held for the whole period. Stimulus windows are always followed by an idle window, so no hit level leaks into the next window. The held-over-level case is the one exception; it deliberately keeps a level high across a strobe.

// File: rtl/ehit_pkg.sv
package ehit_pkg;

  // Strobes the control block hands to the datapath each fast cycle
  typedef struct packed {
    logic restart;   // a new crossing window starts with this sample
    logic publish;   // load the closed window's result into the outputs
    logic trusted;   // the window being closed was fully observed
  } ehitCtl_t;

endpackage

// File: rtl/ehit_prio_enc.sv
module ehit_prio_enc #(
  parameter int WIDTH = 64,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [IDX_W-1:0] lowIdx,
  output logic             anySet
);

  // Lowest set bit wins: the scan runs downward so the last match is the lowest
  always_comb begin
    anySet = |vecIn;
    lowIdx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vecIn[i]) lowIdx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/ehit_ctrl.sv
module ehit_ctrl
  import ehit_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bxStrobe,
  output ehitCtl_t ctl
);

  // Set once the first strobe after reset has opened a complete window
  logic armed;

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else if (bxStrobe) armed <= 1'b1;
  end

  always_comb begin
    ctl.restart = bxStrobe;
    ctl.publish = bxStrobe;
    ctl.trusted = armed;
  end

endmodule

// File: rtl/ehit_datapath.sv
module ehit_datapath
  import ehit_pkg::*;
#(
  parameter int NUM_CH = 64,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ehitCtl_t          ctl,
  input  logic [NUM_CH-1:0] hitIn,
  input  logic [NUM_CH-1:0] chMask,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outValid
);

  logic [NUM_CH-1:0] hitPrev;
  logic [NUM_CH-1:0] freshEdge;
  logic [ADDR_W-1:0] encIdx;
  logic              encAny;
  logic              winFound;
  logic [ADDR_W-1:0] winAddr;
  logic              closeOk;

  // New unmasked rising edges in this sample
  assign freshEdge = hitIn & ~hitPrev & ~chMask;

  ehit_prio_enc #(.WIDTH(NUM_CH)) u_prio (
    .vecIn (freshEdge),
    .lowIdx(encIdx),
    .anySet(encAny)
  );

  assign closeOk = ctl.trusted & winFound;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitPrev  <= '0;
      winFound <= 1'b0;
      winAddr  <= '0;
      outValid <= 1'b0;
      outAddr  <= '0;
    end else begin
      hitPrev <= hitIn;
      if (ctl.publish) begin
        outValid <= closeOk;
        outAddr  <= closeOk ? winAddr : '0;
      end
      if (ctl.restart) begin
        winFound <= encAny;
        winAddr  <= encAny ? encIdx : '0;
      end else if (!winFound && encAny) begin
        winFound <= 1'b1;
        winAddr  <= encIdx;
      end
    end
  end

endmodule

// File: rtl/ehit_encoder.sv
module ehit_encoder
  import ehit_pkg::*;
#(
  parameter int NUM_CH = 64,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bxStrobe,
  input  logic [NUM_CH-1:0] hitIn,
  input  logic [NUM_CH-1:0] chMask,
  output logic [ADDR_W-1:0] hitAddr,
  output logic              hitValid
);

  ehitCtl_t ctl;

  ehit_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bxStrobe(bxStrobe),
    .ctl     (ctl)
  );

  ehit_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .hitIn   (hitIn),
    .chMask  (chMask),
    .outAddr (hitAddr),
    .outValid(hitValid)
  );

endmodule

// File: rtl/ehit_encoder_chk.sv
module ehit_encoder_chk #(
  parameter int NUM_CH = 64,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              bxStrobe,
  input logic [NUM_CH-1:0] hitIn,
  input logic [NUM_CH-1:0] chMask,
  input logic [ADDR_W-1:0] hitAddr,
  input logic              hitValid
);

  // Independent window bookkeeping kept by the checker
  logic [NUM_CH-1:0] cPrev;
  logic              cEdge;
  logic              cSeen;
  logic              sampleEdge;

  assign sampleEdge = |(hitIn & ~cPrev & ~chMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cPrev <= '0;
      cEdge <= 1'b0;
      cSeen <= 1'b0;
    end else begin
      cPrev <= hitIn;
      cEdge <= bxStrobe ? sampleEdge : (cEdge | sampleEdge);
      cSeen <= cSeen | bxStrobe;
    end
  end

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> (hitAddr == '0)); // R8

  AST_HOLD_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    !bxStrobe |=> ($stable(hitAddr) && $stable(hitValid))); // R7

  AST_FIRST_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (bxStrobe && !cSeen) |=> !hitValid); // R9

  AST_FAST_OR: assert property (@(posedge clk) disable iff (!rstN)
    (bxStrobe && cSeen) |=> (hitValid == $past(cEdge))); // R6

endmodule

bind ehit_encoder ehit_encoder_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .bxStrobe(bxStrobe),
  .hitIn   (hitIn),
  .chMask  (chMask),
  .hitAddr (hitAddr),
  .hitValid(hitValid)
);

// File: tb/ehit_encoder_bench.sv
module ehit_encoder_bench;

  localparam int NCH = 64;
  localparam int NVEC = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            bxStrobe = 1'b0;
  logic [NCH-1:0]  hitIn = '0;
  logic [NCH-1:0]  chMask = '0;
  logic [5:0]      hitAddr;
  logic            hitValid;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  ehit_encoder u_ehit_encoder (
    .clk(clk), .rstN(rstN), .bxStrobe(bxStrobe),
    .hitIn(hitIn), .chMask(chMask),
    .hitAddr(hitAddr), .hitValid(hitValid)
  );

  // Vector: chA[31:25] sA[24:23] chB[22:16] sB[15:14] maskCh[13:7] expV[6] expA[5:0]
  // channel value 64 means unused; sX is the window sample (0..3) where it rises
  localparam logic [31:0] VEC [NVEC] = '{
    {7'd64, 2'd0, 7'd64, 2'd0, 7'd64, 1'b0, 6'd0},   // R8 nothing fires
    {7'd5,  2'd0, 7'd64, 2'd0, 7'd64, 1'b1, 6'd5},   // R1 single hit
    {7'd40, 2'd1, 7'd3,  2'd2, 7'd64, 1'b1, 6'd40},  // R2 earlier beats lower
    {7'd50, 2'd2, 7'd10, 2'd2, 7'd64, 1'b1, 6'd10},  // R3 tie
    {7'd63, 2'd3, 7'd64, 2'd0, 7'd64, 1'b1, 6'd63},  // R1 top index, last sample
    {7'd0,  2'd0, 7'd63, 2'd0, 7'd64, 1'b1, 6'd0},   // R3 tie at extremes
    {7'd7,  2'd0, 7'd20, 2'd3, 7'd7,  1'b1, 6'd20},  // R5 masked early hit
    {7'd33, 2'd1, 7'd64, 2'd0, 7'd33, 1'b0, 6'd0},   // R5 masked only hit
    {7'd12, 2'd1, 7'd9,  2'd1, 7'd9,  1'b1, 6'd12},  // R5 masked tie winner
    {7'd2,  2'd3, 7'd1,  2'd2, 7'd64, 1'b1, 6'd1}    // R2 second-last sample wins
  };

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  task automatic drive(input logic s, input logic [NCH-1:0] h);
    @(negedge clk);
    bxStrobe = s;
    hitIn = h;
  endtask

  task automatic checkOut(input string req, input logic expV, input logic [5:0] expA);
    checks++;
    if (hitValid !== expV || hitAddr !== expA) begin
      fails++;
      $display("FAIL %s: actual valid=%0b addr=%0d expected valid=%0b addr=%0d",
               req, hitValid, hitAddr, expV, expA);
    end
  endtask

  // Idle window whose strobe publishes the previous one; checked in all four cycles
  task automatic idleAndCheck(input string req, input logic expV, input logic [5:0] expA);
    for (int j = 0; j < 4; j++) begin
      drive(j == 0, '0);
      @(posedge clk);
      #1;
      checkOut(req, expV, expA);
    end
  endtask

  function automatic logic [NCH-1:0] oneHot(input logic [6:0] ch);
    logic [NCH-1:0] v = '0;
    if (ch < 7'd64) v[ch[5:0]] = 1'b1;
    return v;
  endfunction

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    checkOut("R9 reset", 1'b0, 6'd0);
    rstN = 1'b1;
    // R9 activity before the first strobe is never published
    drive(1'b0, oneHot(7'd11));
    drive(1'b0, oneHot(7'd11));
    drive(1'b1, '0);
    @(posedge clk);
    #1;
    checkOut("R9 first strobe", 1'b0, 6'd0);
    for (int j = 1; j < 4; j++) drive(1'b0, '0);

    // Table walk: stimulus window, then an idle window that publishes it
    for (int v = 0; v < NVEC; v++) begin
      logic [6:0] chA, chB, mk;
      logic [1:0] sA, sB;
      logic [NCH-1:0] h;
      chA = VEC[v][31:25]; sA = VEC[v][24:23];
      chB = VEC[v][22:16]; sB = VEC[v][15:14];
      mk  = VEC[v][13:7];
      chMask = oneHot(mk);
      for (int j = 0; j < 4; j++) begin
        h = '0;
        if (j >= int'(sA)) h |= oneHot(chA);
        if (j >= int'(sB)) h |= oneHot(chB);
        drive(j == 0, h);
      end
      idleAndCheck($sformatf("R6/R7 vector %0d", v), VEC[v][6], VEC[v][5:0]);
    end
    chMask = '0;

    // R4 held-over level: ch8 rises in sample 3, stays high across the strobe
    drive(1'b1, '0);
    drive(1'b0, '0);
    drive(1'b0, '0);
    drive(1'b0, oneHot(7'd8));
    drive(1'b1, oneHot(7'd8));
    @(posedge clk);
    #1;
    checkOut("R4 window with the edge", 1'b1, 6'd8);
    drive(1'b0, oneHot(7'd8));
    drive(1'b0, oneHot(7'd8) | oneHot(7'd30));
    drive(1'b0, oneHot(7'd8) | oneHot(7'd30));
    idleAndCheck("R4 held level ignored", 1'b1, 6'd30);

    // R4 held level alone gives an empty window
    drive(1'b1, '0);
    drive(1'b0, '0);
    drive(1'b0, '0);
    drive(1'b0, oneHot(7'd45));
    drive(1'b1, oneHot(7'd45));
    @(posedge clk);
    #1;
    checkOut("R4 edge in last sample", 1'b1, 6'd45);
    for (int j = 1; j < 4; j++) drive(1'b0, oneHot(7'd45));
    idleAndCheck("R4 held level only", 1'b0, 6'd0);

    // R2 a later lower channel does not replace a winner that has dropped again
    drive(1'b1, oneHot(7'd4));
    drive(1'b0, '0);
    drive(1'b0, oneHot(7'd2));
    drive(1'b0, oneHot(7'd2));
    idleAndCheck("R2 winner kept", 1'b1, 6'd4);

    // R9 reset mid-run clears published result
    drive(1'b1, oneHot(7'd17));
    drive(1'b0, '0);
    drive(1'b0, '0);
    drive(1'b0, '0);
    drive(1'b1, '0);
    @(posedge clk);
    #1;
    checkOut("R1 before reset", 1'b1, 6'd17);
    @(negedge clk);
    bxStrobe = 1'b0;
    rstN = 1'b0;
    @(posedge clk);
    #1;
    checkOut("R9 reset clears", 1'b0, 6'd0);

    finishRun();
  end

endmodule